// File: doc/BRIEF.md
# Serial EEPROM Emulating I2C Slave

This block is an I2C target that behaves like a small byte-addressed serial EEPROM. It watches oversampled SCL and SDA lines from the system clock domain and answers by pulling SDA low through an open-drain enable. Storage is a register array inside the block. An internal address pointer is kept between transactions.

The address byte that follows a START has three parts. Its upper four bits are the fixed code 1010. Its lowest bit gives the transfer direction. The three bits between them are partly chip-select bits and partly high memory address bits. The split depends on the array size: each address bit the array needs above eight takes the place of one select bit, starting from the lowest.

Written bytes are collected in a page buffer and copied into the array only when a STOP arrives. A programming delay then begins, and the block stays silent on the bus until the delay has run out. Reads send bytes from the pointer for as long as the master keeps acknowledging them.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its bits 7..4 are 1010 and each of bits 3..1 that is not used as a memory address bit equals its select pin (bit 1 against selPins[0], bit 2 against selPins[1], bit 3 against selPins[2]). Any other address byte gets no acknowledge, and the block ignores everything after it until the next START.
- R2: As receiver, the block pulls SDA low during the ninth SCL clock after a matching address byte and after every byte written to it. The block changes its SDA drive only while SCL is low, and it does not drive SDA after reset.
- R3: In a write, the first byte after the address byte is the word address. The pointer is loaded with that byte as its low eight bits. Address-byte bits 1 and up, as many as MEM_AW-8, supply the higher pointer bits, starting at bit 8.
- R4: The data bytes of a write reach the array at the STOP. After the STOP the pointer holds the address that follows the last written byte, and this address stays within the page.
- R5: During a page write the low four pointer bits count up after each data byte and roll over within the 16-byte page without changing the upper bits. A seventeenth byte therefore overwrites the first one.
- R6: If a START arrives before the STOP, the data bytes buffered in that write are discarded, and no programming delay begins.
- R7: For BUSY_CYCLES clock cycles after a STOP that commits data, the block acknowledges nothing, not even its own address.
- R8: In a read the block sends each byte MSB first and releases SDA in the ninth clock. After an acknowledge it sends the next byte. After a missing acknowledge it drives nothing until the next START or STOP.
- R9: Each byte sent adds one to the pointer. The pointer rolls over from the last address of the array to address 0.
- R10: A read that is not preceded by a word address starts at the current pointer, which is the address after the byte most recently read or written.
- R11: A write that ends with a STOP after only the word address, or with no data at all, begins no programming delay.
- R12: Bit 0 of the address byte sets the direction: 0 means the master writes and 1 means the block sends data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| selPins | input | 3 | Hard-wired chip-select levels |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The writes cover three cases. A single byte shows that the high address bit from the address byte selects the correct half of the array. A write that starts two bytes before the end of a page shows roll-over within the page, because the following page stays zero. A seventeen-byte burst shows that the first location is overwritten. The reads cover three cases. A random read with a repeated START is compared with a plain current-address read, to tell pointer reload apart from continuation. A read that starts at the last address shows the roll-over to address 0. A write aborted by a repeated START, and a write that carries only a word address, are each followed at once by an address byte. The presence or absence of an acknowledge then shows whether a programming delay was started.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

  // Strobes from the bus controller to the storage datapath
  typedef struct packed {
    logic       ptrLoad;   // load pointer from word address
    logic       bufWrite;  // place byteVal into page buffer
    logic       readAdv;   // current byte handed to bus, advance pointer
    logic       commit;    // STOP seen: program buffered bytes
    logic       clear;     // START seen: drop buffered bytes
    logic [7:0] byteVal;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_DATA, ST_ACK, ST_TX, ST_RACK, ST_HOLD
  } busState_t;

endpackage

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl
  import eeprom_slave_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        selPins,
  input  logic              busy,
  input  logic [7:0]        rdData,
  output dpStrobe_t         stb,
  output logic [MEM_AW-1:0] loadAddr,
  output logic              sdaLow
);

  localparam int HI_BITS = MEM_AW - 8;
  localparam logic [2:0] SEL_MASK = 3'b111 << HI_BITS;

  logic [1:0]  sclSync, sdaSync;
  logic        sclS, sdaS, sclP, sdaP;
  logic        sclRise, sclFall, startEv, stopEv, gate;
  busState_t   state, ackNext;
  logic [3:0]  bitCnt;
  logic [7:0]  shiftReg;
  logic [HI_BITS-1:0] devHi;
  logic        rxState, byteDone, devMatch, loadTx;

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;
  assign gate    = ~busy & ~startEv & ~stopEv;

  assign rxState  = (state == ST_DEV) || (state == ST_WORD) || (state == ST_DATA);
  assign byteDone = rxState && sclFall && (bitCnt == 4'd8);
  assign devMatch = (shiftReg[7:4] == 4'b1010) &&
                    (((shiftReg[3:1] ^ selPins) & SEL_MASK) == 3'b000);
  assign loadTx   = (state == ST_ACK) && sclFall && (ackNext == ST_TX);
  assign loadAddr = {devHi, shiftReg};

  always_comb begin
    stb          = '0;
    stb.byteVal  = shiftReg;
    stb.clear    = ~busy & startEv;
    stb.commit   = ~busy & ~startEv & stopEv;
    stb.ptrLoad  = gate & byteDone & (state == ST_WORD);
    stb.bufWrite = gate & byteDone & (state == ST_DATA);
    stb.readAdv  = gate & loadTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync  <= 2'b11;
      sdaSync  <= 2'b11;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
      state    <= ST_IDLE;
      ackNext  <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      devHi    <= '0;
      sdaLow   <= 1'b0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
      if (busy) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else if (startEv) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopEv) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_WORD, ST_DATA: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (byteDone) begin
              bitCnt <= '0;
              if (state == ST_DEV) begin
                if (devMatch) begin
                  sdaLow  <= 1'b1;
                  state   <= ST_ACK;
                  devHi   <= shiftReg[HI_BITS:1];
                  ackNext <= shiftReg[0] ? ST_TX : ST_WORD;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaLow  <= 1'b1;
                state   <= ST_ACK;
                ackNext <= ST_DATA;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              if (ackNext == ST_TX) begin
                shiftReg <= rdData;
                sdaLow   <= ~rdData[7];
                bitCnt   <= 4'd1;
                state    <= ST_TX;
              end else begin
                sdaLow <= 1'b0;
                bitCnt <= '0;
                state  <= ackNext;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaLow <= 1'b0;
                state  <= ST_RACK;
              end else begin
                shiftReg <= {shiftReg[6:0], 1'b0};
                sdaLow   <= ~shiftReg[6];
                bitCnt   <= bitCnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (sclRise) state <= sdaS ? ST_HOLD : ST_ACK;
          end
          default: ;
        endcase
      end
    end
  end

  // Drive edges only while the clock line is low
  assert_sda_change_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> !sclS);

  // Idle or discarded transaction never holds the line
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_HOLD) |-> !sdaLow);

  // While programming, the line is left alone
  assert_quiet_when_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !sdaLow);

  // Master NACK ends the send phase
  assert_nack_stops_send_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclRise && sdaS && gate) |=> (state == ST_HOLD));

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_slave_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [MEM_AW-1:0] loadAddr,
  output logic [7:0]        rdData,
  output logic              busy
);

  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int PAGE_AW   = $clog2(PAGE_BYTES);
  localparam int BCW       = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            mem     [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [MEM_AW-1:0]     ptr;
  logic [BCW-1:0]        busyCnt;

  assign rdData = mem[ptr];
  assign busy   = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      busyCnt  <= '0;
      bufValid <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (busyCnt != '0) busyCnt <= busyCnt - BCW'(1);
      if (stb.clear) bufValid <= '0;
      if (stb.ptrLoad) ptr <= loadAddr;
      if (stb.bufWrite) begin
        pageBuf[ptr[PAGE_AW-1:0]]  <= stb.byteVal;
        bufValid[ptr[PAGE_AW-1:0]] <= 1'b1;
        ptr[PAGE_AW-1:0]           <= ptr[PAGE_AW-1:0] + PAGE_AW'(1);
      end
      if (stb.readAdv) ptr <= ptr + MEM_AW'(1);
      if (stb.commit && bufValid != '0) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (bufValid[i]) mem[{ptr[MEM_AW-1:PAGE_AW], PAGE_AW'(i)}] <= pageBuf[i];
        bufValid <= '0;
        busyCnt  <= BCW'(BUSY_CYCLES);
      end
    end
  end

  assert_page_upper_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWrite |=> ptr[MEM_AW-1:PAGE_AW] == $past(ptr[MEM_AW-1:PAGE_AW]));

  assert_commit_starts_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && bufValid != '0) |=> busy);

  assert_empty_commit_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && bufValid == '0 && !busy) |=> !busy);

  assert_clear_drops_buffer_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> bufValid == '0);

  assert_read_wraps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readAdv && ptr == '1) |=> ptr == '0);

  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BCW'(BUSY_CYCLES));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int MEM_AW      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] selPins,
  output logic       sdaDriveLow
);
  import eeprom_slave_pkg::*;

  dpStrobe_t         stb;
  logic [MEM_AW-1:0] loadAddr;
  logic [7:0]        rdData;
  logic              busy;

  eeprom_bus_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .selPins(selPins),
    .busy(busy), .rdData(rdData), .stb(stb), .loadAddr(loadAddr), .sdaLow(sdaDriveLow)
  );

  eeprom_store #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .loadAddr(loadAddr), .rdData(rdData), .busy(busy)
  );

endmodule

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
  localparam int AW = 9, BUSY = 300, Q = 8, NB = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaM = 1'b1;
  logic [2:0] sel = 3'b101;
  logic sdaDriveLow, line, prevLow = 1'b0;
  assign line = sdaM & ~sdaDriveLow;

  eeprom_i2c_slave #(.MEM_AW(AW), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(line), .selPins(sel), .sdaDriveLow(sdaDriveLow)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, refPtr = 0;
  logic [7:0] refMem [NB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock reference: drive level may only move while SCL is low (R2)
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (scl && sdaDriveLow !== prevLow) begin
        errors++;
        $display("FAIL R2 drive moved with SCL high actual=%0b expected=%0b", sdaDriveLow, prevLow);
      end
    end
    prevLow = sdaDriveLow;
  end

  task automatic waitq(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    sdaM = 1'b1; waitq(); scl = 1'b1; waitq(); sdaM = 1'b0; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitq(); scl = 1'b1; waitq(); sdaM = 1'b1; waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
    end
    sdaM = 1'b1; waitq(); scl = 1'b1; waitq(); acked = !line; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic readByte(output logic [7:0] v, input bit giveAck);
    sdaM = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      waitq(); scl = 1'b1; waitq(); v = {v[6:0], line}; waitq(); scl = 1'b0;
    end
    waitq(); sdaM = !giveAck; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] dev(input int addr, input bit rd);
    return {4'b1010, sel[2], sel[1], addr[8], rd};
  endfunction

  task automatic writeBytes(input int addr, input logic [7:0] d[$], input bit waitDone);
    bit a;
    int base;
    startCond();
    sendByte(dev(addr, 1'b0), a); chk(a, "R1 address ack", a, 1);
    sendByte(addr[7:0], a);       chk(a, "R3 word ack", a, 1);
    foreach (d[k]) begin
      sendByte(d[k], a);          chk(a, "R2 data ack", a, 1);
    end
    stopCond();
    base = addr & ~15;
    foreach (d[k]) refMem[base | ((addr + k) & 15)] = d[k];
    refPtr = base | ((addr + d.size()) & 15);
    if (waitDone) repeat (BUSY + 40) @(negedge clk);
  endtask

  task automatic readSeq(input int addr, input int n, input string req);
    bit a;
    logic [7:0] v;
    if (addr >= 0) begin
      startCond();
      sendByte(dev(addr, 1'b0), a); chk(a, "R12 write-direction ack", a, 1);
      sendByte(addr[7:0], a);       chk(a, "R3 word ack", a, 1);
      refPtr = addr;
    end
    startCond();
    sendByte(dev(refPtr, 1'b1), a); chk(a, "R12 read-direction ack", a, 1);
    for (int k = 0; k < n; k++) begin
      readByte(v, k < n - 1);
      chk(v == refMem[refPtr], req, v, refMem[refPtr]);
      refPtr = (refPtr + 1) % NB;
    end
    // after NACK the bus stays released (R8)
    waitq(); scl = 1'b1; waitq(); chk(line == 1'b1, "R8 released after NACK", line, 1);
    waitq(); scl = 1'b0; waitq();
    stopCond();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] q[$];
    for (int i = 0; i < NB; i++) refMem[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdaDriveLow == 1'b0, "R2 reset released", sdaDriveLow, 0);

    // R1: wrong fixed code, wrong select bit, then silence until START
    startCond(); sendByte(8'b1011_1000, a); chk(!a, "R1 wrong code nack", a, 0); stopCond();
    startCond(); sendByte({4'b1010, sel[2], ~sel[1], 2'b00}, a); chk(!a, "R1 wrong select nack", a, 0);
    sendByte(8'h55, a); chk(!a, "R1 ignored until START", a, 0); stopCond();

    // R4/R7: byte write with high address bit, then busy deafness
    q = '{8'hA5}; writeBytes(12'h110, q, 1'b0);
    startCond(); sendByte(dev(0, 1'b0), a); chk(!a, "R7 no ack while programming", a, 0); stopCond();
    repeat (BUSY + 40) @(negedge clk);
    readSeq(12'h110, 1, "R3 high-bit random read");
    readSeq(12'h010, 1, "R3 other half untouched");

    // R10: current-address read continues after the last byte
    q = '{8'h11, 8'h22, 8'h33}; writeBytes(12'h030, q, 1'b1);
    readSeq(12'h030, 1, "R10 random read first");
    readSeq(-1, 2, "R10 current-address read");

    // R5: roll-over inside page
    q = '{8'hB0, 8'hB1, 8'hB2, 8'hB3}; writeBytes(12'h04E, q, 1'b1);
    readSeq(12'h04E, 3, "R5 page end and next page");
    readSeq(12'h040, 2, "R5 wrapped bytes");
    q = {};
    for (int k = 0; k < 17; k++) q.push_back(8'(k + 1));
    writeBytes(12'h060, q, 1'b1);
    readSeq(12'h060, 16, "R5 seventeenth overwrites first");

    // R6: repeated START discards buffered data, no busy
    startCond();
    sendByte(dev(12'h080, 1'b0), a); sendByte(8'h80, a); sendByte(8'h77, a);
    startCond();
    sendByte(dev(12'h080, 1'b0), a); chk(a, "R6 ack right after abort", a, 1);
    sendByte(8'h80, a);
    refPtr = 12'h080;
    stopCond();
    readSeq(-1, 1, "R6 aborted byte not stored");

    // R11: word-address-only write starts no programming
    startCond(); sendByte(dev(12'h012, 1'b0), a); sendByte(8'h12, a); stopCond();
    startCond(); sendByte(dev(0, 1'b0), a); chk(a, "R11 ack after address-only write", a, 1); stopCond();

    // R9: sequential read rolls over the array end
    q = '{8'hE1}; writeBytes(12'h1FF, q, 1'b1);
    q = '{8'h0F}; writeBytes(12'h000, q, 1'b1);
    readSeq(12'h1FF, 2, "R9 array roll-over");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule